// File: doc/BRIEF.md
# Receiver Electrical Idle Inference

This block decides, one lane at a time, that the far end of a serial link has stopped transmitting. It does not look at the line voltage. It watches pulses from the receive symbol decoder and infers idle when the event the current mode cares about has been missing for a whole timed window. The event is a comma or skip ordered set, a training ordered set, or an exit from electrical idle.

A 3-bit select code chooses the mode and a 2-bit rate code chooses the data rate. Together they fix which event is watched and how long the window is. Windows given in unit intervals are turned into parallel-clock cycles by dividing by a per-rate UI-per-clock parameter and rounding up. Windows given in milliseconds go through a cycles-per-millisecond parameter, which a bench may shrink. When a mode and rate pair has no defined window, the timer is off and the flag stays low.

Top module: `rx_idle_infer`

## Requirements
- R1: While the top bit of the select code is 0 (codes 000 to 011), the inferred-idle output stays 0 whatever events arrive.
- R2: Select code 100 watches the comma/skip pulse. The window is 128 × CYC_PER_MS cycles at rate codes 00 (Gen1), 01 (Gen2) and 10 (Gen3).
- R3: Select code 101 watches the training-set pulse. The window is ceil(1280 / UI_PER_CLK_G1) cycles at rate 00 and ceil(1280 / UI_PER_CLK_G2) cycles at rate 01.
- R4: Select code 110 watches the idle-exit pulse. The window is ceil(2000 / UI_PER_CLK_G1) cycles at rate 00 and ceil(16000 / UI_PER_CLK_G2) cycles at rate 01.
- R5: Select code 111 watches the idle-exit pulse. The window is 128 × CYC_PER_MS cycles at rate 00.
- R6: Any pair not listed in R2 to R5 keeps the output at 0. This covers codes 101 and 110 at rate 10, code 111 at rates 01 and 10, and every code at rate 11.
- R7: With a window of L cycles, the output rises after exactly L consecutive rising clock edges with no watched event. The count starts at the last edge that sampled a watched event, a select or rate change, or reset. The output then stays high.
- R8: A watched event clears the output and restarts the window at the edge that samples it. Pulses on the two inputs the current mode does not watch have no effect.
- R9: A change in the select code or the rate code clears the output and restarts the window at the edge that samples the change.
- R10: A synchronous active-low reset clears the output and the window counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel receive clock |
| rst_n | input | 1 | Synchronous reset, active low |
| infer_sel_i | input | 3 | Inference mode select |
| rate_i | input | 2 | Line rate: 00 Gen1, 01 Gen2, 10 Gen3, 11 reserved |
| comskp_seen_i | input | 1 | One-cycle pulse: comma or skip ordered set decoded |
| ts_seen_i | input | 1 | One-cycle pulse: training ordered set decoded |
| eidle_exit_seen_i | input | 1 | One-cycle pulse: exit from electrical idle detected |
| idle_inferred_o | output | 1 | Link partner inferred to be electrically idle |

## Verification
The output is a register, so a change in configuration, a watched event or reset shows up as a 0 on the output one edge after it is sampled. A full window of L quiet cycles gives a 1 after edge L+1, counted from the negative edge at which the stimulus was driven. The bench drives stimulus and samples outputs on negative edges and counts edges from the stimulus. It expects the clear at count 1 and the rise at exactly count L+1, where L is computed arithmetically for every select and rate pair. For pairs with no window, it checks that no rise occurs over a span longer than the largest window.

// File: rtl/rxei_pkg.sv
// Package: shared codes for receiver electrical idle inference.
// Assumes the select code is 3 bits and the rate code is 2 bits.
package rxei_pkg;
    localparam logic [1:0] RATE_G1 = 2'b00;
    localparam logic [1:0] RATE_G2 = 2'b01;
    localparam logic [1:0] RATE_G3 = 2'b10;

    localparam logic [2:0] SEL_COMSKP = 3'b100;
    localparam logic [2:0] SEL_TS     = 3'b101;
    localparam logic [2:0] SEL_EXIT_S = 3'b110;
    localparam logic [2:0] SEL_EXIT_L = 3'b111;

    // Integer ceiling division, used for UI-to-cycle conversion.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/rxei_window_lut.sv
// Module: maps select and rate codes to a window length in cycles and an
// enable. Assumes every defined window is at least 1 cycle and fits CNT_W.
module rxei_window_lut
    import rxei_pkg::*;
#(
    parameter int UI_PER_CLK_G1 = 20,
    parameter int UI_PER_CLK_G2 = 20,
    parameter int CYC_PER_MS    = 125000,
    parameter int CNT_W         = 25
) (
    input  logic [2:0]       sel_i,
    input  logic [1:0]       rate_i,
    output logic             en_o,
    output logic [CNT_W-1:0] limit_o
);
    localparam int LEN_MS128   = 128 * CYC_PER_MS;
    localparam int LEN_TS_G1   = ceil_div(1280, UI_PER_CLK_G1);
    localparam int LEN_TS_G2   = ceil_div(1280, UI_PER_CLK_G2);
    localparam int LEN_EXIT_G1 = ceil_div(2000, UI_PER_CLK_G1);
    localparam int LEN_EXIT_G2 = ceil_div(16000, UI_PER_CLK_G2);

    // Purpose: look up the window for the current mode and rate pair.
    always_comb begin
        en_o    = 1'b0;
        limit_o = '0;
        unique case (sel_i)
            SEL_COMSKP: if (rate_i == RATE_G1 || rate_i == RATE_G2 || rate_i == RATE_G3) begin
                en_o    = 1'b1;
                limit_o = CNT_W'(LEN_MS128);
            end
            SEL_TS: if (rate_i == RATE_G1) begin
                en_o    = 1'b1;
                limit_o = CNT_W'(LEN_TS_G1);
            end else if (rate_i == RATE_G2) begin
                en_o    = 1'b1;
                limit_o = CNT_W'(LEN_TS_G2);
            end
            SEL_EXIT_S: if (rate_i == RATE_G1) begin
                en_o    = 1'b1;
                limit_o = CNT_W'(LEN_EXIT_G1);
            end else if (rate_i == RATE_G2) begin
                en_o    = 1'b1;
                limit_o = CNT_W'(LEN_EXIT_G2);
            end
            SEL_EXIT_L: if (rate_i == RATE_G1) begin
                en_o    = 1'b1;
                limit_o = CNT_W'(LEN_MS128);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxei_event_pick.sv
// Module: selects which decoder pulse restarts the window for the current
// mode. Assumes the pulses are already in the parallel clock domain.
module rxei_event_pick
    import rxei_pkg::*;
(
    input  logic [2:0] sel_i,
    input  logic       comskp_i,
    input  logic       ts_i,
    input  logic       exit_i,
    output logic       event_o
);
    // Purpose: route the one watched pulse; the other pulses are dropped.
    always_comb begin
        unique case (sel_i)
            SEL_COMSKP:             event_o = comskp_i;
            SEL_TS:                 event_o = ts_i;
            SEL_EXIT_S, SEL_EXIT_L: event_o = exit_i;
            default:                event_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rxei_cfg_watch.sv
// Module: flags any change of the configuration word since the last edge.
// Assumes the configuration may change on any cycle; loads it during reset.
module rxei_cfg_watch #(
    parameter int CFG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             changed_o
);
    logic [CFG_W-1:0] cfg_q;

    // Purpose: keep last cycle's configuration (taken as-is during reset).
    always_ff @(posedge clk) begin
        cfg_q <= cfg_i;
        if (!rst_n) cfg_q <= cfg_i;
    end

    // Purpose: report a difference against the stored configuration.
    assign changed_o = (cfg_i != cfg_q);
endmodule

// File: rtl/rxei_window_timer.sv
// Module: saturating quiet-cycle counter with a registered idle flag.
// Assumes limit_i >= 1 whenever en_i is high and is stable unless restart_i.
module rxei_window_timer #(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic             event_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             flag_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;

    // Purpose: count quiet edges up to the limit and raise the flag there.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || !en_i || event_i) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (cnt_q < limit_i) begin
            cnt_q  <= cnt_q + 1'b1;
            flag_q <= ((cnt_q + 1'b1) == limit_i);
        end else begin
            flag_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= limit_i) || restart_i || !en_i);

    p_rise_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(cnt_q) == limit_i - 1'b1) && !$past(event_i));

    p_event_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        event_i |=> !flag_q && (cnt_q == '0));

    p_restart_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !flag_q && (cnt_q == '0));
endmodule

// File: rtl/rx_idle_infer.sv
// Module: top of receiver electrical idle inference for one lane.
// Assumes decoder pulses and codes are synchronous to clk; reset is
// synchronous and active low.
module rx_idle_infer #(
    parameter int UI_PER_CLK_G1 = 20,
    parameter int UI_PER_CLK_G2 = 20,
    parameter int CYC_PER_MS    = 125000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] infer_sel_i,
    input  logic [1:0] rate_i,
    input  logic       comskp_seen_i,
    input  logic       ts_seen_i,
    input  logic       eidle_exit_seen_i,
    output logic       idle_inferred_o
);
    localparam int CNT_W = $clog2(128 * CYC_PER_MS + 16001) + 1;

    logic             win_en;
    logic [CNT_W-1:0] win_len;
    logic             watched_ev;
    logic             cfg_changed;

    rxei_window_lut #(
        .UI_PER_CLK_G1(UI_PER_CLK_G1),
        .UI_PER_CLK_G2(UI_PER_CLK_G2),
        .CYC_PER_MS   (CYC_PER_MS),
        .CNT_W        (CNT_W)
    ) lut_i (
        .sel_i  (infer_sel_i),
        .rate_i (rate_i),
        .en_o   (win_en),
        .limit_o(win_len)
    );

    rxei_event_pick pick_i (
        .sel_i   (infer_sel_i),
        .comskp_i(comskp_seen_i),
        .ts_i    (ts_seen_i),
        .exit_i  (eidle_exit_seen_i),
        .event_o (watched_ev)
    );

    rxei_cfg_watch #(.CFG_W(5)) watch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_i    ({infer_sel_i, rate_i}),
        .changed_o(cfg_changed)
    );

    rxei_window_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (win_en),
        .restart_i(cfg_changed),
        .event_i  (watched_ev),
        .limit_i  (win_len),
        .flag_o   (idle_inferred_o)
    );

    p_off_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !infer_sel_i[2] |=> !idle_inferred_o);

    p_undef_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |=> !idle_inferred_o);

    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> !idle_inferred_o);
endmodule

// File: tb/rx_idle_infer_tb_top.sv
module rx_idle_infer_tb_top;
    localparam int U1   = 20;
    localparam int U2   = 40;
    localparam int MS   = 2;
    localparam int MAXW = 500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'b100;
    logic [1:0] rate = 2'b00;
    logic       ev_c = 1'b0, ev_t = 1'b0, ev_x = 1'b0;
    logic       idle;
    int         total = 0;
    int         bad = 0;

    always #2.5 clk = ~clk;

    rx_idle_infer #(.UI_PER_CLK_G1(U1), .UI_PER_CLK_G2(U2), .CYC_PER_MS(MS)) dut_i (
        .clk(clk), .rst_n(rst_n), .infer_sel_i(sel), .rate_i(rate),
        .comskp_seen_i(ev_c), .ts_seen_i(ev_t), .eidle_exit_seen_i(ev_x),
        .idle_inferred_o(idle)
    );

    function automatic int cdiv(int n, int d);
        return (n + d - 1) / d;
    endfunction

    // Expected window in cycles per R2..R6; 0 means no window.
    function automatic int exp_len(int s, int r);
        case (s)
            4: return (r < 3) ? 128 * MS : 0;
            5: return (r == 0) ? cdiv(1280, U1) : (r == 1) ? cdiv(1280, U2) : 0;
            6: return (r == 0) ? cdiv(2000, U1) : (r == 1) ? cdiv(16000, U2) : 0;
            7: return (r == 0) ? 128 * MS : 0;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(int s, int len);
        if (s < 4) return "R1";
        if (len == 0) return "R6";
        case (s)
            4: return "R2";
            5: return "R3";
            6: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive pulses on the events that mode s does not watch.
    task automatic foreign(input int s, input bit v);
        ev_c = (s != 4) ? v : 1'b0;
        ev_t = (s != 5) ? v : 1'b0;
        ev_x = (s < 6)  ? v : 1'b0;
    endtask

    // Step edges from count k until the flag is high or MAXW is reached.
    task automatic run_to_rise(input int s, input bit fg, inout int k);
        while (!idle && k < MAXW) begin
            @(posedge clk);
            @(negedge clk);
            k++;
            if (fg) foreign(s, k[0]);
        end
        foreign(s, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(idle == 1'b0, "R10", idle, 0);
        rst_n = 1'b1;
        for (int s = 0; s < 8; s++) begin
            for (int r = 0; r < 4; r++) begin
                int len;
                int k;
                string rq;
                len = exp_len(s, r);
                rq  = req_of(s, len);
                @(negedge clk);
                sel = 3'(s); rate = 2'(r);
                @(posedge clk); @(negedge clk);
                k = 1;
                chk(idle == 1'b0, "R9", idle, 0);
                run_to_rise(s, (len == 0), k);
                if (len == 0) begin
                    chk(idle == 1'b0, rq, idle, 0);
                end else begin
                    chk(k == len + 1, rq, k, len + 1);
                    // Own event clears, foreign ones are ignored (R8), then full window (R7).
                    case (s)
                        4: ev_c = 1'b1;
                        5: ev_t = 1'b1;
                        default: ev_x = 1'b1;
                    endcase
                    @(posedge clk); @(negedge clk);
                    ev_c = 1'b0; ev_t = 1'b0; ev_x = 1'b0;
                    k = 1;
                    chk(idle == 1'b0, "R8", idle, 0);
                    run_to_rise(s, 1'b1, k);
                    chk(k == len + 1, "R7", k, len + 1);
                end
            end
        end
        // Reset mid-window with flag high, then window counted from reset (R10).
        begin
            int k;
            int len;
            len = exp_len(6, 0);
            @(negedge clk);
            sel = 3'b110; rate = 2'b00;
            k = 0;
            run_to_rise(6, 1'b0, k);
            chk(idle == 1'b1, "R4", idle, 1);
            rst_n = 1'b0;
            @(posedge clk); @(negedge clk);
            rst_n = 1'b1;
            k = 1;
            chk(idle == 1'b0, "R10", idle, 0);
            run_to_rise(6, 1'b0, k);
            chk(k == len + 1, "R10", k, len + 1);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule